// File: doc/BRIEF.md
# ARC4 Keystream Engine

This block generates an ARC4 keystream behind a 32-bit register bus. Software loads a key of 1 to 16 bytes into four key words and then writes the key length, stored as the byte count minus one. That write resets the 256-entry byte state to the identity permutation. It then runs the key-scheduling permutation at one step per clock. When scheduling ends, the engine raises a done flag and an interrupt flag, and it returns keystream bytes on a simple request/valid port, one byte per served request.

The interrupt flag and the interrupt pin are kept apart. The flag in the status word always records that scheduling has finished. A mask bit in the control word only decides whether the flag reaches the pin. Any write to the interrupt-clear address drops the flag. A self-clearing software-reset bit in the control word does the same as the reset input.

Top module: `arc4_engine`

## Requirements
- R1: After reset the control word (address 0) reads 0x8000_0000, with the mask at bit 31 set. The status word (address 1) reads 0, `irq` is low and no keystream is served. Control bits 29 to 0 always read 0, whatever was written to them.
- R2: Writing the control word with bit 30 set makes bit 30 read 1 for exactly one cycle. On the next clock the engine and all registers return to the R1 state, as they would with `rst_n`.
- R3: Status bit 0 (interrupt flag) sets when scheduling completes, whatever the value of mask bit 31. `irq` follows that flag while the mask is 0 and stays low while the mask is 1.
- R4: Any write to address 2 clears status bit 0 and `irq`. The written data has no effect.
- R5: A write to address 3 starts scheduling. Status bit 2 (busy) is then high for exactly 256 cycles. On the cycle it falls, status bit 1 (done) and status bit 0 set together.
- R6: Addresses 4 to 7 hold the key words from least to most significant. Key byte n is bits 8*(n mod 4)+7 to 8*(n mod 4) of the word at address 4 + n/4. Bits 3 to 0 of the address-3 write give the key length minus one (lengths 1 to 16). Key bytes at or above the length are not used.
- R7: Each request served after scheduling returns the next ARC4 output byte. `ks_valid` is high with `ks_byte` in the cycle after the request is sampled, so a held request gives one byte per cycle.
- R8: A request made while the engine is busy, has never scheduled, or has just been reset is not served: `ks_valid` stays low.
- R9: A new address-3 write, made during scheduling or after some keystream has been read, restarts from the identity state. The keystream that follows matches a fresh run with the current key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (control and status; others read 0) |
| ks_req | input | 1 | Keystream byte request |
| ks_valid | output | 1 | Keystream byte valid |
| ks_byte | output | 8 | Keystream byte |
| irq | output | 1 | Interrupt output, gated by the mask |

## Verification
The hardest situation to reach from the ports is a request that is already pending when scheduling ends. The request must stay unserved for all 256 busy cycles and then produce exactly the first keystream byte. The bench raises `ks_req` right after the length write and watches `ks_valid` on every busy cycle, then checks the first served byte against a reference model. It also restarts scheduling while it is running and issues a software reset in the middle of a schedule. Each key length from 1 to 16 is swept and compared against an ARC4 model in the bench.

// File: rtl/arc4_pkg.sv
package arc4_pkg;
   localparam int BUS_W = 32;
   localparam int SB_W  = 8;
   localparam int SB_N  = 1 << SB_W;

   // register word addresses
   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_ICLR = 2;
   localparam int A_KLEN = 3;
   localparam int A_KEY  = 4;

   // control and status bit positions
   localparam int CTRL_MASK = 31;
   localparam int CTRL_SRST = 30;
   localparam int ST_IRQ    = 0;
   localparam int ST_DONE   = 1;
   localparam int ST_BUSY   = 2;

   typedef enum logic [1:0] {ENG_IDLE, ENG_SCHED, ENG_READY} eng_t;
endpackage

// File: rtl/arc4_regs.sv
module arc4_regs
   import arc4_pkg::*;
#(
   parameter int KEY_BYTES = 16,
   parameter int ADDR_W    = 3,
   localparam int KEY_WORDS = KEY_BYTES / 4,
   localparam int LEN_W     = $clog2(KEY_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [BUS_W-1:0]           wdata,
   input  logic                       sched_done,
   input  logic                       busy,
   input  logic                       done,
   output logic [BUS_W-1:0]           rdata,
   output logic [KEY_WORDS*BUS_W-1:0] key_flat,
   output logic [LEN_W-1:0]           klen,
   output logic                       start,
   output logic                       soft_rst,
   output logic                       irq_flag,
   output logic                       mask_q,
   output logic                       irq
);
   logic wr_ctrl, wr_iclr;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
   assign wr_iclr = wr_en && (addr == ADDR_W'(A_ICLR));
   assign start   = wr_en && (addr == ADDR_W'(A_KLEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_rst <= 1'b0;
         mask_q   <= 1'b1;
         irq_flag <= 1'b0;
         klen     <= '0;
      end else begin
         soft_rst <= !soft_rst && wr_ctrl && wdata[CTRL_SRST];
         if (soft_rst) begin
            mask_q   <= 1'b1;
            irq_flag <= 1'b0;
            klen     <= '0;
         end else begin
            if (wr_ctrl)         mask_q   <= wdata[CTRL_MASK];
            if (sched_done)      irq_flag <= 1'b1;
            else if (wr_iclr)    irq_flag <= 1'b0;
            if (start)           klen     <= wdata[LEN_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_flat <= '0;
      end else if (soft_rst) begin
         key_flat <= '0;
      end else begin
         for (int w = 0; w < KEY_WORDS; w++) begin
            if (wr_en && (addr == ADDR_W'(A_KEY + w)))
               key_flat[w*BUS_W +: BUS_W] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL)) begin
         rdata[CTRL_MASK] = mask_q;
         rdata[CTRL_SRST] = soft_rst;
      end else if (addr == ADDR_W'(A_STAT)) begin
         rdata[ST_IRQ]  = irq_flag;
         rdata[ST_DONE] = done;
         rdata[ST_BUSY] = busy;
      end
   end

   assign irq = irq_flag && !mask_q;
endmodule

// File: rtl/arc4_core.sv
module arc4_core
   import arc4_pkg::*;
#(
   parameter int KEY_BYTES = 16,
   localparam int KEY_WORDS = KEY_BYTES / 4,
   localparam int LEN_W     = $clog2(KEY_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       srst,
   input  logic                       start,
   input  logic [KEY_WORDS*BUS_W-1:0] key_flat,
   input  logic [LEN_W-1:0]           klen,
   input  logic                       ks_req,
   output logic                       busy,
   output logic                       done,
   output logic                       sched_done,
   output logic                       ks_valid,
   output logic [SB_W-1:0]            ks_byte
);
   eng_t            fsm;
   logic [SB_W-1:0] sbox [SB_N];
   logic [SB_W-1:0] i_q, j_q, ia, jb, sa, sb, kb, t, ks_next;
   logic [LEN_W-1:0] kidx;
   logic            sched, ready, last, do_init, do_swap;

   assign sched   = (fsm == ENG_SCHED);
   assign ready   = (fsm == ENG_READY);
   assign last    = (i_q == SB_W'(SB_N - 1));
   assign do_init = start && !srst;
   assign do_swap = !srst && !start && (sched || (ready && ks_req));
   assign kb      = key_flat[{kidx, 3'b000} +: SB_W];

   // one swap step: scheduling adds the key byte, streaming pre-increments i
   always_comb begin
      ia      = sched ? i_q : i_q + SB_W'(1);
      sa      = sbox[ia];
      jb      = j_q + sa + (sched ? kb : '0);
      sb      = sbox[jb];
      t       = sa + sb;
      if (t == ia)      ks_next = sb;
      else if (t == jb) ks_next = sa;
      else              ks_next = sbox[t];
   end

   always_ff @(posedge clk) begin
      if (do_init) begin
         for (int k = 0; k < SB_N; k++) sbox[k] <= SB_W'(k);
      end else if (do_swap) begin
         sbox[ia] <= sb;
         sbox[jb] <= sa;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm <= ENG_IDLE;  i_q <= '0;  j_q <= '0;  kidx <= '0;
         done <= 1'b0;  ks_valid <= 1'b0;  ks_byte <= '0;
      end else if (srst) begin
         fsm <= ENG_IDLE;  i_q <= '0;  j_q <= '0;  kidx <= '0;
         done <= 1'b0;  ks_valid <= 1'b0;  ks_byte <= '0;
      end else begin
         ks_valid <= 1'b0;
         if (start) begin
            fsm  <= ENG_SCHED;
            i_q  <= '0;
            j_q  <= '0;
            kidx <= '0;
            done <= 1'b0;
         end else if (sched) begin
            i_q  <= i_q + SB_W'(1);
            j_q  <= last ? '0 : jb;
            kidx <= (kidx == klen) ? '0 : kidx + LEN_W'(1);
            if (last) begin
               fsm  <= ENG_READY;
               done <= 1'b1;
            end
         end else if (ready && ks_req) begin
            i_q      <= ia;
            j_q      <= jb;
            ks_valid <= 1'b1;
            ks_byte  <= ks_next;
         end
      end
   end

   assign busy       = sched;
   assign sched_done = sched && last && !srst && !start;
endmodule

// File: rtl/arc4_engine.sv
module arc4_engine
   import arc4_pkg::*;
#(
   parameter int KEY_BYTES = 16,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ks_req,
   output logic              ks_valid,
   output logic [7:0]        ks_byte,
   output logic              irq
);
   localparam int KEY_WORDS = KEY_BYTES / 4;
   localparam int LEN_W     = $clog2(KEY_BYTES);

   generate
      if (KEY_BYTES < 4 || KEY_BYTES > 16 || (KEY_BYTES & (KEY_BYTES - 1)) != 0)
         $error("KEY_BYTES must be 4, 8 or 16");
      if ((1 << ADDR_W) < A_KEY + KEY_WORDS)
         $error("ADDR_W too small for the key words");
   endgenerate

   logic [KEY_WORDS*BUS_W-1:0] key_flat;
   logic [LEN_W-1:0]           klen;
   logic start, soft_rst, irq_flag, mask_q, busy, done, sched_done;

   arc4_regs #(.KEY_BYTES(KEY_BYTES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .sched_done(sched_done), .busy(busy), .done(done), .rdata(bus_rdata),
      .key_flat(key_flat), .klen(klen), .start(start), .soft_rst(soft_rst),
      .irq_flag(irq_flag), .mask_q(mask_q), .irq(irq)
   );

   arc4_core #(.KEY_BYTES(KEY_BYTES)) u_core (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst), .start(start), .key_flat(key_flat),
      .klen(klen), .ks_req(ks_req), .busy(busy), .done(done), .sched_done(sched_done),
      .ks_valid(ks_valid), .ks_byte(ks_byte)
   );
endmodule

// File: rtl/arc4_engine_chk.sv
module arc4_engine_chk
   import arc4_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq,
   input logic              ks_valid,
   input logic              irq_flag,
   input logic              mask_q,
   input logic              soft_rst,
   input logic              busy,
   input logic              done,
   input logic              sched_done
);
   logic clr_wr;
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(A_ICLR));

   AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst); // R2
   AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mask_q && !done && !busy && !irq_flag)); // R2
   AST_FLAG_SETS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      sched_done |=> irq_flag); // R3
   AST_MASK_BLOCKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq); // R3
   AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !sched_done) |=> (!irq_flag && !irq)); // R4
   AST_DONE_AFTER_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
      sched_done |=> (done && !busy)); // R5
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R5
   AST_NO_STREAM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ks_valid); // R8
endmodule

bind arc4_engine arc4_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq),
   .ks_valid(ks_valid), .irq_flag(irq_flag), .mask_q(mask_q), .soft_rst(soft_rst),
   .busy(busy), .done(done), .sched_done(sched_done)
);

// File: tb/arc4_engine_test.sv
module arc4_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ks_req = 1'b0;
   logic        ks_valid;
   logic [7:0]  ks_byte;
   logic        irq;

   int total = 0;
   int bad   = 0;

   logic [7:0] kb [16];
   logic [7:0] rs [256];
   int         ri, rj;

   always #10 clk = ~clk;

   arc4_engine uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ks_req(ks_req),
      .ks_valid(ks_valid), .ks_byte(ks_byte), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 3'(a);
      #1 d = bus_rdata;
   endtask

   // reference model
   task automatic ref_sched(input int len);
      logic [7:0] tmp;
      int j = 0;
      for (int k = 0; k < 256; k++) rs[k] = 8'(k);
      for (int k = 0; k < 256; k++) begin
         j = (j + int'(rs[k]) + int'(kb[k % len])) & 255;
         tmp = rs[k]; rs[k] = rs[j]; rs[j] = tmp;
      end
      ri = 0; rj = 0;
   endtask

   task automatic ref_next(output logic [7:0] b);
      logic [7:0] tmp;
      ri = (ri + 1) & 255;
      rj = (rj + int'(rs[ri])) & 255;
      tmp = rs[ri]; rs[ri] = rs[rj]; rs[rj] = tmp;
      b = rs[(int'(rs[ri]) + int'(rs[rj])) & 255];
   endtask

   task automatic write_key();
      for (int w = 0; w < 4; w++)
         wr(4 + w, {kb[4*w+3], kb[4*w+2], kb[4*w+1], kb[4*w]});
   endtask

   task automatic wait_done(output int cyc);
      logic [31:0] s;
      cyc = 0;
      rd(1, s);
      while (s[2] && cyc < 1000) begin
         cyc++;
         @(negedge clk);
         rd(1, s);
      end
   endtask

   task automatic get_byte(output logic [7:0] b, output logic v);
      ks_req = 1'b1;
      @(negedge clk);
      ks_req = 1'b0;
      v = ks_valid;
      b = ks_byte;
   endtask

   task automatic stream_check(input int n, input string req);
      logic [7:0] b, e;
      logic v;
      for (int k = 0; k < n; k++) begin
         get_byte(b, v);
         ref_next(e);
         check(v === 1'b1, req, "ks_valid", 32'(v), 32'd1);
         check(b === e, req, "keystream byte", 32'(b), 32'(e));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      logic        v;
      int          cyc;
      int          hits;
      logic [7:0]  kvec [5];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, d); check(d === 32'h8000_0000, "R1", "control after reset", d, 32'h8000_0000);
      rd(1, d); check(d === 32'h0, "R1", "status after reset", d, 32'h0);
      check(irq === 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);

      // R8 request before any schedule is ignored
      get_byte(b, v);
      check(v === 1'b0, "R8", "valid with no key", 32'(v), 32'd0);

      // R6/R7 known vector: key "Key"
      for (int k = 0; k < 16; k++) kb[k] = 8'h0;
      kb[0] = 8'h4B; kb[1] = 8'h65; kb[2] = 8'h79;
      kvec[0] = 8'hEB; kvec[1] = 8'h9F; kvec[2] = 8'h77; kvec[3] = 8'h81; kvec[4] = 8'hB7;
      write_key();
      wr(3, 32'h2);
      ref_sched(3);
      wait_done(cyc);
      check(cyc == 256, "R5", "busy cycles", 32'(cyc), 32'd256);
      rd(1, d); check(d === 32'h3, "R5", "status after schedule", d, 32'h3);
      check(irq === 1'b0, "R3", "irq masked while flag set", 32'(irq), 32'd0);
      for (int k = 0; k < 5; k++) begin
         get_byte(b, v);
         check(v === 1'b1 && b === kvec[k], "R6", "known vector byte", 32'(b), 32'(kvec[k]));
      end

      // R3 unmask, R1 reserved bits
      wr(0, 32'h0);
      check(irq === 1'b1, "R3", "irq after unmask", 32'(irq), 32'd1);
      wr(0, 32'h0FFF_FFFF);
      rd(0, d); check(d === 32'h0, "R1", "reserved control bits", d, 32'h0);

      // R4 clear interrupt with arbitrary data
      wr(2, 32'hDEAD_BEEF);
      rd(1, d); check(d === 32'h2, "R4", "status after clear", d, 32'h2);
      check(irq === 1'b0, "R4", "irq after clear", 32'(irq), 32'd0);

      // R6/R7/R9 sweep over every key length
      for (int len = 1; len <= 16; len++) begin
         for (int k = 0; k < 16; k++) kb[k] = 8'(len * 37 + k * 11 + 5);
         write_key();
         wr(3, 32'(len - 1));
         ref_sched(len);
         wait_done(cyc);
         check(cyc == 256, "R5", "busy cycles in sweep", 32'(cyc), 32'd256);
         check(irq === 1'b1, "R3", "irq unmasked after schedule", 32'(irq), 32'd1);
         stream_check(10, "R7");
         wr(2, 32'h0);
      end

      // R8 request held across scheduling
      for (int k = 0; k < 16; k++) kb[k] = 8'(k * 29 + 3);
      write_key();
      wr(3, 32'h4);
      ref_sched(5);
      ks_req = 1'b1;
      hits = 0;
      rd(1, d);
      while (d[2]) begin
         if (ks_valid) hits++;
         @(negedge clk);
         rd(1, d);
      end
      check(hits == 0, "R8", "valid during busy", 32'(hits), 32'd0);
      @(negedge clk);
      ks_req = 1'b0;
      ref_next(b);
      check(ks_valid === 1'b1 && ks_byte === b, "R8", "first byte after stall", 32'(ks_byte), 32'(b));
      wr(2, 32'h0);

      // R9 restart in the middle of scheduling
      for (int k = 0; k < 16; k++) kb[k] = 8'(k * 7 + 90);
      write_key();
      wr(3, 32'h6);
      repeat (100) @(negedge clk);
      for (int k = 0; k < 16; k++) kb[k] = 8'(k * 13 + 200);
      write_key();
      wr(3, 32'hB);
      ref_sched(12);
      wait_done(cyc);
      check(cyc == 256, "R9", "busy cycles after restart", 32'(cyc), 32'd256);
      stream_check(12, "R9");

      // R2 software reset after streaming
      wr(0, 32'h4000_0000);
      rd(0, d); check(d === 32'h4000_0000, "R2", "reset bit visible one cycle", d, 32'h4000_0000);
      @(negedge clk);
      rd(0, d); check(d === 32'h8000_0000, "R2", "control after soft reset", d, 32'h8000_0000);
      rd(1, d); check(d === 32'h0, "R2", "status after soft reset", d, 32'h0);
      check(irq === 1'b0, "R2", "irq after soft reset", 32'(irq), 32'd0);
      get_byte(b, v);
      check(v === 1'b0, "R8", "valid after soft reset", 32'(v), 32'd0);

      // R2 software reset during scheduling
      write_key();
      wr(3, 32'hF);
      repeat (50) @(negedge clk);
      wr(0, 32'h4000_0000);
      @(negedge clk);
      rd(1, d); check(d === 32'h0, "R2", "status after reset mid-schedule", d, 32'h0);
      repeat (300) @(negedge clk);
      rd(1, d); check(d === 32'h0, "R2", "schedule stays cancelled", d, 32'h0);

      // engine usable again after soft reset
      for (int k = 0; k < 16; k++) kb[k] = 8'(255 - k * 3);
      write_key();
      wr(3, 32'h7);
      ref_sched(8);
      wait_done(cyc);
      check(cyc == 256, "R5", "busy cycles after soft reset", 32'(cyc), 32'd256);
      stream_check(8, "R7");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule